// File: doc/BRIEF.md
# FEAC Channel Transmitter

This block serialises the far-end alarm and control message of a DS3 C-bit parity stream. A host writes one 8-bit message byte into the block. Each time the surrounding framer offers a FEAC bit slot (a one-cycle strobe), the block presents one bit on its serial output. A valid byte is sent as a repeating 16-bit codeword: an 8-bit flag of all ones, then the message byte, least significant bit first.

A byte whose top or bottom bit is set is not a valid message. For such a byte the channel sends idle ones and raises no interrupt. When a codeword carrying a valid byte completes, the block raises an interrupt status bit. The next host write clears that bit. A byte written in the middle of a codeword is held until the codeword ends, so a codeword never mixes two messages. When C-bit parity mode is off, the output is held at ones and the sequencer stays at the start of a codeword.

Top module: `feac_tx`

## Requirements
- R1: While `cbit_mode_i` is 0, `tx_bit_o` is 1 on every bit strobe and `irq_o` is never set by a completed codeword.
- R2: A codeword is 16 strobes long: strobes 0 to 7 emit the flag (all ones), and strobes 8 to 15 emit message bits 0 to 7 in that order. Each strobe advances exactly one bit, and cycles without a strobe do not advance it.
- R3: A byte is valid when bit 7 is 0 and bit 0 is 0. While the active byte is invalid (for example 0x81, 0x01 or 0x80), `tx_bit_o` is 1 on every strobe.
- R4: A valid byte that is not rewritten is sent again in every following codeword.
- R5: On the strobe that ends a codeword whose byte is valid, `irq_o` rises on the following clock edge.
- R6: A codeword that carries an invalid byte does not set `irq_o`.
- R7: A host write (`wr_en_i` high) clears `irq_o` on the next clock edge. A write wins over a codeword completion in the same cycle.
- R8: A byte written in the middle of a codeword first appears in the codeword that starts after the current one ends. A write on the last strobe of a codeword applies to the codeword after the next one.
- R9: After reset the stored byte is 0xFF (invalid), `tx_bit_o` is 1, `irq_o` is 0, and the sequencer is at the first flag bit.
- R10: Clearing `cbit_mode_i` returns the sequencer to the first flag bit. When the mode is set again, the next codeword starts with the flag and carries the latest written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cbit_mode_i | input | 1 | C-bit parity mode select; transmitter is active only when 1 |
| wr_en_i | input | 1 | Host write strobe for the message byte |
| wr_data_i | input | 8 | Message byte written by the host |
| bit_strobe_i | input | 1 | One-cycle FEAC bit opportunity |
| tx_bit_o | output | 1 | Serial FEAC bit, valid in the cycle `bit_strobe_i` is high |
| irq_o | output | 1 | Transmit-complete interrupt status |

## Verification
The channel is driven with the valid bytes 0x42, 0x3C and 0x5A, whose distinct bit patterns expose a reversed bit order, an off-by-one shift or a missing flag. It is also driven with the invalid bytes 0x81, 0x01 and 0x80, which check each marker bit alone and both together. Strobes arrive back to back and also with idle gaps, which separates strobe-driven advance from free-running advance. Writes fall mid-codeword, on the final strobe and while the mode is off, which tests the boundary load, the write-over-set priority and the restart from the flag.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;
  // A message byte is valid only with both marker bits cleared.
  function automatic logic msg_valid(input logic msb, input logic lsb);
    return !msb && !lsb;
  endfunction
endpackage

// File: rtl/feac_tx_msg_reg.sv
module feac_tx_msg_reg #(
  parameter int MSG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic             done_i,
  output logic [MSG_W-1:0] msg_o,
  output logic             irq_o
);
  logic [MSG_W-1:0] msg_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q <= '1;
      irq_q <= 1'b0;
    end else begin
      if (wr_en_i) msg_q <= wr_data_i;
      // host write has priority over a completing codeword
      if (wr_en_i)     irq_q <= 1'b0;
      else if (done_i) irq_q <= 1'b1;
    end
  end

  assign msg_o = msg_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/feac_tx_seq.sv
module feac_tx_seq
  import feac_tx_pkg::*;
#(
  parameter int MSG_W  = 8,
  parameter int FLAG_W = 8,
  localparam int CW_LEN = MSG_W + FLAG_W,
  localparam int POS_W  = $clog2(CW_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cbit_mode_i,
  input  logic             strobe_i,
  input  logic [MSG_W-1:0] msg_i,
  output logic [POS_W-1:0] pos_o,
  output logic [MSG_W-1:0] act_o,
  output logic             act_valid_o,
  output logic             done_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CW_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic [MSG_W-1:0] act_q;
  logic             at_last;

  assign at_last     = (pos_q == LAST_POS);
  assign act_valid_o = msg_valid(act_q[MSG_W-1], act_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      act_q <= '1;
    end else if (!cbit_mode_i) begin
      // parked at codeword start, tracking the host byte
      pos_q <= '0;
      act_q <= msg_i;
    end else if (strobe_i) begin
      if (at_last) begin
        pos_q <= '0;
        act_q <= msg_i;
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign done_o = cbit_mode_i && strobe_i && at_last && act_valid_o;
  assign pos_o  = pos_q;
  assign act_o  = act_q;
endmodule

// File: rtl/feac_tx_bit_sel.sv
module feac_tx_bit_sel #(
  parameter int MSG_W  = 8,
  parameter int FLAG_W = 8,
  localparam int CW_LEN = MSG_W + FLAG_W,
  localparam int POS_W  = $clog2(CW_LEN)
) (
  input  logic             cbit_mode_i,
  input  logic [MSG_W-1:0] act_i,
  input  logic             act_valid_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             bit_o
);
  logic [CW_LEN-1:0] cw;

  // flag in the low positions so it leaves first
  assign cw    = {act_i, {FLAG_W{1'b1}}};
  assign bit_o = (cbit_mode_i && act_valid_i) ? cw[pos_i] : 1'b1;
endmodule

// File: rtl/feac_tx.sv
module feac_tx #(
  parameter int MSG_W  = 8,
  parameter int FLAG_W = 8,
  localparam int CW_LEN = MSG_W + FLAG_W,
  localparam int POS_W  = $clog2(CW_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cbit_mode_i,
  input  logic             wr_en_i,
  input  logic [MSG_W-1:0] wr_data_i,
  input  logic             bit_strobe_i,
  output logic             tx_bit_o,
  output logic             irq_o
);
  logic [MSG_W-1:0] msg;
  logic [MSG_W-1:0] act;
  logic [POS_W-1:0] pos;
  logic             act_valid;
  logic             done;

  feac_tx_msg_reg #(.MSG_W(MSG_W)) u_msg_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .done_i    (done),
    .msg_o     (msg),
    .irq_o     (irq_o)
  );

  feac_tx_seq #(.MSG_W(MSG_W), .FLAG_W(FLAG_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cbit_mode_i (cbit_mode_i),
    .strobe_i    (bit_strobe_i),
    .msg_i       (msg),
    .pos_o       (pos),
    .act_o       (act),
    .act_valid_o (act_valid),
    .done_o      (done)
  );

  feac_tx_bit_sel #(.MSG_W(MSG_W), .FLAG_W(FLAG_W)) u_bit_sel (
    .cbit_mode_i (cbit_mode_i),
    .act_i       (act),
    .act_valid_i (act_valid),
    .pos_i       (pos),
    .bit_o       (tx_bit_o)
  );
endmodule

// File: rtl/feac_tx_chk.sv
module feac_tx_chk #(
  parameter int MSG_W  = 8,
  parameter int FLAG_W = 8,
  localparam int CW_LEN = MSG_W + FLAG_W,
  localparam int POS_W  = $clog2(CW_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cbit_mode_i,
  input logic             wr_en_i,
  input logic             bit_strobe_i,
  input logic             tx_bit_o,
  input logic             irq_o,
  input logic [POS_W-1:0] pos_i,
  input logic             act_valid_i
);
  localparam logic [POS_W-1:0] FLAG_END = POS_W'(FLAG_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CW_LEN - 1);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cbit_mode_i |-> tx_bit_o); // R1

  AST_FLAG_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cbit_mode_i && pos_i < FLAG_END) |-> tx_bit_o); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cbit_mode_i && !bit_strobe_i) |=> $stable(pos_i)); // R2

  AST_INVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_valid_i |-> tx_bit_o); // R3

  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cbit_mode_i && bit_strobe_i && act_valid_i && pos_i == LAST_POS)); // R5

  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !irq_o); // R7

  AST_OFF_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cbit_mode_i |=> pos_i == '0); // R10
endmodule

bind feac_tx feac_tx_chk #(.MSG_W(MSG_W), .FLAG_W(FLAG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cbit_mode_i  (cbit_mode_i),
  .wr_en_i      (wr_en_i),
  .bit_strobe_i (bit_strobe_i),
  .tx_bit_o     (tx_bit_o),
  .irq_o        (irq_o),
  .pos_i        (pos),
  .act_valid_i  (act_valid)
);

// File: tb/feac_tx_test.sv
module feac_tx_test;
  localparam int PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       strobe = 1'b0;
  logic       tx_bit;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  // reference state, updated per clock edge
  int         m_pos = 0;
  logic [7:0] m_msg = 8'hFF;
  logic [7:0] m_act = 8'hFF;
  logic       m_irq = 1'b0;

  feac_tx uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cbit_mode_i  (mode),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .bit_strobe_i (strobe),
    .tx_bit_o     (tx_bit),
    .irq_o        (irq)
  );

  always #(PER/2) clk = ~clk;

  function automatic logic ok_byte(input logic [7:0] b);
    return !b[7] && !b[0];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle of stimulus; pushes the expected bit for a strobe
  task automatic step(input logic md, input logic st, input logic wr,
                      input logic [7:0] d, input string tag);
    logic set;
    @(negedge clk);
    mode = md; strobe = st; wr_en = wr; wr_data = d;
    if (st) begin
      exp_q.push_back((md && ok_byte(m_act) && m_pos >= 8) ? m_act[m_pos-8] : 1'b1);
      tag_q.push_back(tag);
    end
    set = 1'b0;
    if (!md) begin
      m_pos = 0; m_act = m_msg;
    end else if (st) begin
      if (m_pos == 15) begin
        set = ok_byte(m_act); m_act = m_msg; m_pos = 0;
      end else m_pos++;
    end
    if (wr) m_irq = 1'b0;
    else if (set) m_irq = 1'b1;
    if (wr) m_msg = d;
  endtask

  task automatic check_irq(input string tag);
    @(posedge clk);
    #(PER/4);
    chk(tag, irq, m_irq);
  endtask

  task automatic strobes(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 8'h00, tag);
  endtask

  task automatic to_boundary(input string tag);
    while (m_pos != 0) step(1'b1, 1'b1, 1'b0, 8'h00, tag);
  endtask

  // monitor: pops one expectation per observed strobe
  initial begin
    forever begin
      @(negedge clk);
      #(PER/4);
      if (strobe) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 actual=unexpected strobe expected=queued item");
        end else begin
          logic e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, tx_bit, e);
        end
      end
    end
  end

  initial begin
    #(PER * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 tx after reset", tx_bit, 1'b1);
    chk("R9 irq after reset", irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // mode off: ones only, no interrupt
    step(1'b0, 1'b0, 1'b1, 8'h42, "R1");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, 8'h00, "R1");
    check_irq("R1 irq while off");

    // first codeword with 0x42, then repeats
    strobes(16, "R2");
    check_irq("R5 irq after codeword");
    strobes(16, "R4");
    strobes(16, "R4");
    check_irq("R5 irq still pending");

    step(1'b1, 1'b0, 1'b1, 8'h42, "R7");
    check_irq("R7 write clears irq");

    // mid-codeword write of 0x3C
    strobes(5, "R8");
    step(1'b1, 1'b1, 1'b1, 8'h3C, "R8");
    strobes(10, "R8");
    strobes(32, "R8");

    // strobes with idle gaps
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b1, 1'b0, 8'h00, "R2 gapped");
      step(1'b1, 1'b0, 1'b0, 8'h00, "R2 gapped");
      step(1'b1, 1'b0, 1'b0, 8'h00, "R2 gapped");
    end

    // write on the final strobe: write wins, byte lands one codeword later
    while (m_pos != 15) step(1'b1, 1'b1, 1'b0, 8'h00, "R8");
    step(1'b1, 1'b1, 1'b1, 8'h5A, "R8 last-strobe write");
    check_irq("R7 write beats completion");
    strobes(32, "R8");

    // invalid bytes
    step(1'b1, 1'b0, 1'b1, 8'h81, "R3");
    to_boundary("R3");
    strobes(16, "R3");
    step(1'b1, 1'b0, 1'b1, 8'h81, "R6");
    check_irq("R6 cleared before invalid run");
    strobes(32, "R3");
    check_irq("R6 no irq for 0x81");
    step(1'b1, 1'b0, 1'b1, 8'h01, "R3");
    to_boundary("R3");
    strobes(16, "R3 0x01");
    check_irq("R6 no irq for 0x01");
    step(1'b1, 1'b0, 1'b1, 8'h80, "R3");
    to_boundary("R3");
    strobes(16, "R3 0x80");
    check_irq("R6 no irq for 0x80");

    // mode drop mid codeword restarts from the flag
    step(1'b1, 1'b0, 1'b1, 8'h42, "R10");
    to_boundary("R10");
    strobes(16, "R10");
    strobes(6, "R10");
    step(1'b0, 1'b1, 1'b1, 8'h5A, "R10 off");
    step(1'b0, 1'b1, 1'b0, 8'h00, "R10 off");
    check_irq("R10 irq cleared by write while off");
    strobes(16, "R10 restart");
    check_irq("R10 irq after restarted codeword");
    strobes(8, "R10");

    step(1'b1, 1'b0, 1'b0, 8'h00, "end");
    step(1'b1, 1'b0, 1'b0, 8'h00, "end");
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule